// File: doc/BRIEF.md
# Keyword Store with Single-Fetch Control

This block keeps a small queue of control words for a sequence generator. It also controls how those words leave the queue. Words go in through a plain write port. On the read side the words are not streamed. A fetch controller issues one strobe of one clock width. That strobe pops the oldest word into a held output register. The controller then refuses to fetch again until the consumer reports, on its done input, that it has finished with the current word. The consumer decides how long to keep a word, for example from a cycle-count field carried in the word itself. Throughout that time the output register holds the word without change.

The controller has three states. IDLE is left for ARMED when the overall read enable is high. ARMED drives the fetch strobe in any cycle where the read enable is high and the queue holds a word. A strobe moves it to HOLD. If the read enable drops, ARMED returns to IDLE. HOLD waits for done. On done it goes to ARMED if the read enable is high, and to IDLE otherwise. A done that arrives in ARMED or IDLE is ignored. The depth and the word width are parameters. The defaults are four entries of twelve bits.

Top module: `kw_fetch_store`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `fetch_pulse` is 0 and `word_out` is all zeros.
- R2: A write with `wr_en` high while not full stores `wr_word` at the tail. `full` is 1 exactly when DEPTH words are stored. `empty` is 1 exactly when none are stored, and the two flags are never 1 together.
- R3: A write while full is ignored. The stored contents and their order do not change, and the dropped word never reaches `word_out`.
- R4: When `rd_enable` is sampled high in IDLE, `fetch_pulse` is 1 in the next cycle, provided a word is stored. At the clock edge that ends that cycle, `word_out` takes the oldest stored word.
- R5: `fetch_pulse` is never 1 in two consecutive cycles. After a strobe, no further strobe occurs until `used_up` has been sampled high.
- R6: `used_up` sampled high in HOLD, with `rd_enable` high and a word stored, gives `fetch_pulse` = 1 in the very next cycle.
- R7: `word_out` changes only at the edge that ends a `fetch_pulse` cycle. It stays stable for the whole consumer hold time, which the bench takes from the word's top three bits.
- R8: A done that finds the queue empty leaves the controller waiting with no strobe. A `used_up` in ARMED has no effect. `fetch_pulse` rises in the cycle after the edge that writes a word.
- R9: While `rd_enable` is low, `fetch_pulse` is 0. A done in HOLD with `rd_enable` low leads to IDLE, and no strobe occurs until `rd_enable` is high again.
- R10: `fetch_pulse` is never 1 while `empty` is 1, so no read is ever taken from an empty queue.
- R11: The read and write pointers wrap modulo DEPTH and carry one extra bit, so first-in first-out order holds across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | WORD_W | Word to write |
| rd_enable | input | 1 | Overall read-enable request |
| used_up | input | 1 | Consumer done with the held word |
| fetch_pulse | output | 1 | One-cycle fetch strobe; pops at the edge that ends it |
| word_out | output | WORD_W | Held output word |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds DEPTH words |

## Verification
On every cycle, the assertions check the following:
- The strobe is never high in two consecutive cycles.
- No strobe occurs between a fetch and the next done.
- No strobe occurs without the read enable or with an empty queue.
- The held word does not move outside a fetch.
- Full stays set under a rejected write.

Several behaviours can only be shown by the bench's scenarios, because they need a reference queue:
- Words come out in the order written, across many pointer wraps.
- A word written while full never appears.
- A waiting controller fetches in the cycle after a late write.
- The hold time follows each word's own count field.

// File: rtl/kwf_pkg.sv
package kwf_pkg;

    typedef enum logic [1:0] {
        KW_IDLE  = 2'd0,
        KW_ARMED = 2'd1,
        KW_HOLD  = 2'd2
    } kw_state_e;

endpackage

// File: rtl/kwf_store.sv
module kwf_store #(
    parameter int WORD_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] din,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              is_empty,
    output logic              is_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]     wptr_q;
    logic [PW-1:0]     rptr_q;
    logic              push_ok;
    logic              pop_ok;

    // Equal indices with equal wrap bits means empty; a differing wrap bit means full.
    assign is_empty = (wptr_q == rptr_q);
    assign is_full  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);
    assign push_ok  = push && !is_full;
    assign pop_ok   = pop && !is_empty;
    assign head     = mem_q[rptr_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wptr_q[AW-1:0]] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_ok) begin
                wptr_q <= wptr_q + PW'(1);
            end
            if (pop_ok) begin
                rptr_q <= rptr_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/kwf_ctrl.sv
module kwf_ctrl
    import kwf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_enable,
    input  logic used_up,
    input  logic store_empty,
    output logic fetch
);
    kw_state_e state_q;
    kw_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output: the strobe is issued only from ARMED, with a request and a word available.
    always_comb begin
        fetch = 1'b0;
        unique case (state_q)
            KW_IDLE:  fetch = 1'b0;
            KW_ARMED: fetch = rd_enable && !store_empty;
            KW_HOLD:  fetch = 1'b0;
            default:  fetch = 1'b0;
        endcase
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KW_IDLE: begin
                if (rd_enable) begin
                    state_d = KW_ARMED;
                end
            end
            KW_ARMED: begin
                if (!rd_enable) begin
                    state_d = KW_IDLE;
                end else if (!store_empty) begin
                    state_d = KW_HOLD;
                end
            end
            KW_HOLD: begin
                if (used_up) begin
                    state_d = rd_enable ? KW_ARMED : KW_IDLE;
                end
            end
            default: state_d = KW_IDLE;
        endcase
    end

endmodule

// File: rtl/kwf_hold.sv
module kwf_hold #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/kw_fetch_store.sv
module kw_fetch_store #(
    parameter int WORD_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_enable,
    input  logic              used_up,
    output logic              fetch_pulse,
    output logic [WORD_W-1:0] word_out,
    output logic              empty,
    output logic              full
);
    logic [WORD_W-1:0] head_w;
    logic              empty_w;
    logic              full_w;
    logic              fetch_w;

    kwf_store #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en),
        .din      (wr_word),
        .pop      (fetch_w),
        .head     (head_w),
        .is_empty (empty_w),
        .is_full  (full_w)
    );

    kwf_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_enable   (rd_enable),
        .used_up     (used_up),
        .store_empty (empty_w),
        .fetch       (fetch_w)
    );

    kwf_hold #(
        .WORD_W (WORD_W)
    ) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fetch_w),
        .din   (head_w),
        .dout  (word_out)
    );

    assign fetch_pulse = fetch_w;
    assign empty       = empty_w;
    assign full        = full_w;

endmodule

// File: rtl/kwf_checker.sv
module kwf_checker #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_enable,
    input logic              used_up,
    input logic              fetch_pulse,
    input logic [WORD_W-1:0] word_out,
    input logic              empty,
    input logic              full
);
    // Set by a strobe, cleared by a sampled done.
    logic waiting_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (fetch_pulse) begin
            waiting_q <= 1'b1;
        end else if (used_up) begin
            waiting_q <= 1'b0;
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pulse |=> !fetch_pulse);

    a_r5_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
        waiting_q |-> !fetch_pulse);

    a_r9_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pulse |-> rd_enable);

    a_r10_no_empty_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pulse |-> !empty);

    a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_pulse |=> $stable(word_out));

    a_r3_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !fetch_pulse) |=> full);

    always @(posedge clk) begin
        if (rst_n) begin
            a_r2_flags_exclusive: assert (!(full && empty));
        end
    end

endmodule

bind kw_fetch_store kwf_checker #(.WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_enable   (rd_enable),
    .used_up     (used_up),
    .fetch_pulse (fetch_pulse),
    .word_out    (word_out),
    .empty       (empty),
    .full        (full)
);

// File: tb/kw_fetch_store_tb.sv
module kw_fetch_store_tb_top;
    localparam int PERIOD = 10;
    localparam int W      = 12;
    localparam int D      = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_word = '0;
    logic         rd_enable = 1'b0;
    logic         used_up = 1'b0;
    logic         fetch_pulse;
    logic [W-1:0] word_out;
    logic         empty;
    logic         full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;
    logic [W-1:0] q[$];
    logic [W-1:0] held;

    always #(PERIOD/2) clk = ~clk;

    kw_fetch_store #(.WORD_W(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .rd_enable(rd_enable), .used_up(used_up), .fetch_pulse(fetch_pulse),
        .word_out(word_out), .empty(empty), .full(full)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk(input int i);
        logic [2:0] c;
        c = 3'((i % 4) + 1);
        return {c, 9'(i * 37 + 5)};
    endfunction

    // Write one word; the model drops it when full (R3).
    task automatic put(input logic [W-1:0] w);
        wr_en = 1'b1;
        wr_word = w;
        tick();
        wr_en = 1'b0;
        if (q.size() < D) q.push_back(w);
        chk("R2 full", 32'(full), 32'(q.size() == D));
        chk("R2 empty", 32'(empty), 32'(q.size() == 0));
    endtask

    // Expects ARMED with a word ready: strobe, hold for count cycles, then done.
    task automatic consume();
        logic [W-1:0] e;
        int n;
        e = q.pop_front();
        chk("R4/R6 strobe", 32'(fetch_pulse), 32'd1);
        tick();
        chk("R4 R11 word order", 32'(word_out), 32'(e));
        chk("R5 strobe width", 32'(fetch_pulse), 32'd0);
        n = int'(e[W-1:W-3]);
        for (int k = 0; k < n; k++) begin
            tick();
            chk("R7 held word", 32'(word_out), 32'(e));
            chk("R5 no strobe before done", 32'(fetch_pulse), 32'd0);
        end
        used_up = 1'b1;
        tick();
        used_up = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 strobe", 32'(fetch_pulse), 32'd0);
        chk("R1 word", 32'(word_out), 32'd0);

        // Fill, then overfill (R2, R3).
        for (int i = 0; i < D; i++) put(mk(i));
        put(12'hABC);
        chk("R3 still full", 32'(full), 32'd1);

        // Raise the request from IDLE (R4).
        rd_enable = 1'b1;
        chk("R9 idle no strobe", 32'(fetch_pulse), 32'd0);
        tick();
        for (int i = 0; i < D; i++) consume();

        // Empty: done already given, controller waits (R8, R10).
        chk("R8 empty", 32'(empty), 32'd1);
        chk("R8 no strobe when empty", 32'(fetch_pulse), 32'd0);
        held = word_out;
        used_up = 1'b1;
        tick();
        used_up = 1'b0;
        tick();
        chk("R8 done in ARMED ignored", 32'(fetch_pulse), 32'd0);
        chk("R8 word unchanged", 32'(word_out), 32'(held));
        put(mk(40));
        chk("R8 late strobe", 32'(fetch_pulse), 32'd1);
        consume();

        // Request dropped in HOLD (R9).
        rd_enable = 1'b0;
        tick();
        put(mk(41));
        put(mk(42));
        rd_enable = 1'b1;
        tick();
        chk("R4 strobe after raise", 32'(fetch_pulse), 32'd1);
        held = q.pop_front();
        tick();
        chk("R4 word", 32'(word_out), 32'(held));
        rd_enable = 1'b0;
        used_up = 1'b1;
        tick();
        used_up = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 no strobe without request", 32'(fetch_pulse), 32'd0);
            chk("R9 word held", 32'(word_out), 32'(held));
        end
        rd_enable = 1'b1;
        tick();
        consume();

        // Request dropped in ARMED (R9).
        put(mk(43));
        chk("R8 strobe after write", 32'(fetch_pulse), 32'd1);
        rd_enable = 1'b0;
        #1;
        chk("R9 strobe gated", 32'(fetch_pulse), 32'd0);
        rd_enable = 1'b1;
        #1;
        chk("R9 strobe restored", 32'(fetch_pulse), 32'd1);
        consume();

        // Wrap sweep (R11).
        for (int r = 0; r < 8; r++) begin
            rd_enable = 1'b0;
            for (int j = 0; j < (r % D) + 1; j++) put(mk(100 + r * 5 + j));
            rd_enable = 1'b1;
            tick();
            for (int j = 0; j < (r % D) + 1; j++) consume();
            chk("R11 drained", 32'(empty), 32'd1);
        end

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule